// File: doc/BRIEF.md
# Wave Sample Table Access Arbiter

This block keeps the small sample table that a wave-playback channel steps through, and decides what a CPU byte access to that table touches. Each byte packs two 4-bit samples, so a 16-byte table holds 32 sample positions. While the channel is stopped, the CPU reads and writes whichever byte its own index selects. While the channel plays, the channel's current sample position takes over. The byte the CPU reaches is the position divided by two. How much of that access is allowed depends on which hardware variant is selected.

On the older variant, an access made during playback only works while the channel raises its readable-window flag. Outside that window a read returns all ones and a write is dropped. On the newer variant, a write made during playback still goes to the CPU's own index. A read made during playback returns the byte under the current position, whatever the window flag says. The block also feeds the channel one registered 4-bit sample per clock, picked from the byte under the current position. Producing the sample timing is left to the channel.

Top module: `wave_ram_arbiter`

## Requirements
- R1: While reset is asserted and right after it is released, every table byte is 0x00 and `smp_out` is 0.
- R2: With `ch_playing` low, a write stores `cpu_wdata` at byte `cpu_idx`, visible from the next cycle. A read returns byte `cpu_idx` combinationally on `cpu_rdata`.
- R3: With `ch_playing` high, `variant_new` low and `ch_window` high, `cpu_rdata` returns byte `ch_pos[4:1]` and ignores `cpu_idx`.
- R4: With `ch_playing` high, `variant_new` low and `ch_window` low, `cpu_rdata` is 0xFF.
- R5: With `ch_playing` high, `variant_new` low and `ch_window` high, a write stores `cpu_wdata` at byte `ch_pos[4:1]` and leaves byte `cpu_idx` untouched (when the two differ).
- R6: With `ch_playing` high, `variant_new` low and `ch_window` low, a write changes no byte of the table.
- R7: With `ch_playing` high and `variant_new` high, a write stores `cpu_wdata` at byte `cpu_idx`, whatever `ch_window` is.
- R8: With `ch_playing` high and `variant_new` high, `cpu_rdata` returns byte `ch_pos[4:1]`, whatever `ch_window` is.
- R9: One cycle after any clock edge, `smp_out` holds the sample at position `ch_pos` as it was before that edge. Bits 7:4 of a byte are its even sample (`ch_pos[0]`=0) and bits 3:0 its odd sample (`ch_pos[0]`=1). The byte is taken as it was before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| cpu_idx | input | 4 | CPU byte index into the table |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| ch_playing | input | 1 | Wave channel is running |
| ch_window | input | 1 | Channel's readable-window flag |
| ch_pos | input | 5 | Channel's current sample position |
| variant_new | input | 1 | 1 selects the newer variant's access rules, 0 the older |
| smp_out | output | 4 | Registered sample delivered to the channel |

## Verification
The bench builds the block with its default parameters: 16 bytes of 8 bits, a 4-bit index and a 5-bit position. At that size a few thousand random cycles can reach every byte, both nibbles and each combination of playing, window and variant many times over. The bench's reference table decides what each access touches with its own if-chain. The test that follows playback most closely is a blocked write on the older variant. It is followed by an idle readback of all sixteen bytes, which proves that nothing moved. A newer-variant write aimed away from the playing position checks that the write is not redirected.

// File: rtl/wave_ram_pkg.sv
package wave_ram_pkg;

  // How a CPU read is served this cycle
  typedef enum logic [1:0] {
    RD_DIRECT  = 2'd0,  // use the CPU index
    RD_FOLLOW  = 2'd1,  // use the channel's current byte
    RD_BLOCKED = 2'd2   // return all ones
  } rd_mode_e;

  typedef struct packed {
    rd_mode_e rd_mode;
    logic     wr_en;      // a write reaches the table
    logic     wr_follow;  // the write targets the channel's current byte
  } access_plan_t;

  // Access decision from channel state, variant and write strobe
  function automatic access_plan_t plan_access(input logic playing,
                                               input logic window,
                                               input logic newer,
                                               input logic wr);
    access_plan_t p;
    if (!playing)            p.rd_mode = RD_DIRECT;
    else if (newer || window) p.rd_mode = RD_FOLLOW;
    else                     p.rd_mode = RD_BLOCKED;
    p.wr_en     = wr && (!playing || newer || window);
    p.wr_follow = playing && !newer;
    return p;
  endfunction

endpackage

// File: rtl/wave_access_ctrl.sv
module wave_access_ctrl
  import wave_ram_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int POS_W = IDX_W + 1
) (
  input  logic             cpu_wr,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             ch_playing,
  input  logic             ch_window,
  input  logic [POS_W-1:0] ch_pos,
  input  logic             variant_new,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_blocked,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] play_idx
);

  access_plan_t plan;

  // Byte under the channel's current sample position
  function automatic logic [IDX_W-1:0] byte_of_pos(input logic [POS_W-1:0] pos);
    return pos[POS_W-1:1];
  endfunction

  always_comb begin
    plan     = plan_access(ch_playing, ch_window, variant_new, cpu_wr);
    play_idx = byte_of_pos(ch_pos);
    rd_idx   = (plan.rd_mode == RD_DIRECT) ? cpu_idx : play_idx;
    rd_blocked = (plan.rd_mode == RD_BLOCKED);
    wr_en    = plan.wr_en;
    wr_idx   = plan.wr_follow ? play_idx : cpu_idx;
  end

endmodule

// File: rtl/wave_store.sv
module wave_store #(
  parameter int NUM_BYTES = 16,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(NUM_BYTES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [IDX_W-1:0]              widx,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [IDX_W-1:0]              ridx,
  output logic [DATA_W-1:0]             rdata,
  input  logic [IDX_W-1:0]              sidx,
  output logic [DATA_W-1:0]             sdata,
  output logic [NUM_BYTES*DATA_W-1:0]   tbl_flat
);

  logic [DATA_W-1:0] mem [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)                                 mem[g] <= '0;
      else if (we && (widx == IDX_W'(g)))         mem[g] <= wdata;
    end
    assign tbl_flat[g*DATA_W +: DATA_W] = mem[g];
  end

  assign rdata = mem[ridx];
  assign sdata = mem[sidx];

endmodule

// File: rtl/wave_sample_out.sv
module wave_sample_out #(
  parameter int DATA_W = 8,
  localparam int SMP_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              odd_sel,
  output logic [SMP_W-1:0]  smp_out
);

  // Even sample lives in the upper half, odd sample in the lower half
  function automatic logic [SMP_W-1:0] pick_half(input logic [DATA_W-1:0] b,
                                                 input logic odd);
    return odd ? b[SMP_W-1:0] : b[DATA_W-1:SMP_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) smp_out <= '0;
    else        smp_out <= pick_half(byte_in, odd_sel);
  end

endmodule

// File: rtl/wave_ram_arbiter.sv
module wave_ram_arbiter #(
  parameter int NUM_BYTES = 16,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(NUM_BYTES),
  localparam int POS_W    = IDX_W + 1,
  localparam int SMP_W    = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              ch_playing,
  input  logic              ch_window,
  input  logic [POS_W-1:0]  ch_pos,
  input  logic              variant_new,
  output logic [SMP_W-1:0]  smp_out
);

  logic [IDX_W-1:0]            rd_idx, wr_idx, play_idx;
  logic                        rd_blocked, wr_en;
  logic [DATA_W-1:0]           rd_byte, play_byte;
  logic [NUM_BYTES*DATA_W-1:0] tbl_flat;

  wave_access_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .cpu_wr      (cpu_wr),
    .cpu_idx     (cpu_idx),
    .ch_playing  (ch_playing),
    .ch_window   (ch_window),
    .ch_pos      (ch_pos),
    .variant_new (variant_new),
    .rd_idx      (rd_idx),
    .rd_blocked  (rd_blocked),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .play_idx    (play_idx)
  );

  wave_store #(.NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_en),
    .widx     (wr_idx),
    .wdata    (cpu_wdata),
    .ridx     (rd_idx),
    .rdata    (rd_byte),
    .sidx     (play_idx),
    .sdata    (play_byte),
    .tbl_flat (tbl_flat)
  );

  wave_sample_out #(.DATA_W(DATA_W)) u_smp (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_in (play_byte),
    .odd_sel (ch_pos[0]),
    .smp_out (smp_out)
  );

  assign cpu_rdata = rd_blocked ? {DATA_W{1'b1}} : rd_byte;

  // Helpers for the checks below
  function automatic logic [DATA_W-1:0] byte_at(input logic [NUM_BYTES*DATA_W-1:0] t,
                                                input logic [IDX_W-1:0] i);
    return t[int'(i)*DATA_W +: DATA_W];
  endfunction

  function automatic logic [SMP_W-1:0] sample_at(input logic [NUM_BYTES*DATA_W-1:0] t,
                                                 input logic [POS_W-1:0] p);
    logic [DATA_W-1:0] b;
    b = t[int'(p[POS_W-1:1])*DATA_W +: DATA_W];
    return p[0] ? b[SMP_W-1:0] : b[DATA_W-1:SMP_W];
  endfunction

  // R2
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !ch_playing) |=> byte_at(tbl_flat, $past(cpu_idx)) == $past(cpu_wdata));

  // R4
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_playing && !ch_window && !variant_new) |-> (cpu_rdata == {DATA_W{1'b1}}));

  // R5
  follow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && ch_playing && ch_window && !variant_new)
      |=> byte_at(tbl_flat, $past(ch_pos[POS_W-1:1])) == $past(cpu_wdata));

  // R6
  dropped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_playing && !ch_window && !variant_new) |=> $stable(tbl_flat));

  // R7
  newer_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && ch_playing && variant_new)
      |=> byte_at(tbl_flat, $past(cpu_idx)) == $past(cpu_wdata));

  // R9
  sample_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> smp_out == sample_at($past(tbl_flat), $past(ch_pos)));

endmodule

// File: tb/tb_wave_ram_arbiter.sv
module tb_wave_ram_arbiter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_wr;
  logic [3:0] cpu_idx;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic       ch_playing, ch_window, variant_new;
  logic [4:0] ch_pos;
  logic [3:0] smp_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;  // 125 MHz

  wave_ram_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_idx(cpu_idx),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ch_playing(ch_playing),
    .ch_window(ch_window), .ch_pos(ch_pos), .variant_new(variant_new),
    .smp_out(smp_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference read: what the CPU should see this cycle
  function automatic logic [7:0] exp_read(input logic [3:0] idx, input logic [4:0] pos,
                                          input logic pl, input logic win, input logic nv);
    if (!pl) return model[idx];
    if (nv)  return model[pos >> 1];
    if (win) return model[pos >> 1];
    return 8'hFF;
  endfunction

  function automatic logic [3:0] exp_smp(input logic [4:0] pos);
    logic [7:0] b;
    b = model[pos / 2];
    return (pos % 2 == 0) ? b[7:4] : b[3:0];
  endfunction

  function automatic string read_tag(input logic pl, input logic win, input logic nv);
    if (!pl) return "R2";
    if (nv)  return "R8";
    if (win) return "R3";
    return "R4";
  endfunction

  // One cycle: drive at the falling edge, check read, clock, check sample
  task automatic step(input logic wr, input logic [3:0] idx, input logic [7:0] wd,
                      input logic pl, input logic win, input logic nv,
                      input logic [4:0] pos);
    logic [3:0] es;
    cpu_wr = wr; cpu_idx = idx; cpu_wdata = wd;
    ch_playing = pl; ch_window = win; variant_new = nv; ch_pos = pos;
    #2;
    chk(read_tag(pl, win, nv), cpu_rdata, exp_read(idx, pos, pl, win, nv));
    es = exp_smp(pos);
    if (wr) begin
      if (!pl || nv)    model[idx] = wd;      // R2 / R7
      else if (win)     model[pos >> 1] = wd; // R5
      // else dropped: R6
    end
    @(posedge clk); #2;
    chk("R9", {4'h0, smp_out}, {4'h0, es});
    @(negedge clk);
  endtask

  task automatic readback_all(input string req);
    for (int i = 0; i < 16; i++) begin
      cpu_wr = 1'b0; cpu_idx = 4'(i); ch_playing = 1'b0;
      #2;
      chk(req, cpu_rdata, model[i]);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_idx = '0; cpu_wdata = '0;
    ch_playing = 1'b0; ch_window = 1'b0; variant_new = 1'b0; ch_pos = '0;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    // R1 during reset
    chk("R1", {4'h0, smp_out}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    readback_all("R1");
    #2; chk("R1", {4'h0, smp_out}, 8'h00);
    @(negedge clk);

    // R2 idle fill and readback
    for (int i = 0; i < 16; i++) step(1'b1, 4'(i), 8'(i * 17 + 3), 1'b0, 1'b0, 1'b0, 5'd0);
    readback_all("R2");

    // R3 / R9 older variant, window open, both nibbles
    step(1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 5'd7);
    step(1'b0, 4'd0, 8'h00, 1'b1, 1'b1, 1'b0, 5'd6);
    // R4 window closed
    step(1'b0, 4'd9, 8'h00, 1'b1, 1'b0, 1'b0, 5'd31);

    // R5 write follows the position, not cpu_idx
    step(1'b1, 4'd0, 8'hA5, 1'b1, 1'b1, 1'b0, 5'd10);
    cpu_wr = 1'b0; cpu_idx = 4'd5; ch_playing = 1'b0; #2;
    chk("R5", cpu_rdata, 8'hA5);
    @(negedge clk);
    cpu_idx = 4'd0; #2;
    chk("R5", cpu_rdata, 8'h03);
    @(negedge clk);

    // R6 dropped writes, then prove nothing moved
    for (int i = 0; i < 16; i++) step(1'b1, 4'(i), 8'h5A, 1'b1, 1'b0, 1'b0, 5'(2 * i));
    readback_all("R6");

    // R7 / R8 newer variant, window closed, write away from play position
    step(1'b1, 4'd2, 8'h3C, 1'b1, 1'b0, 1'b1, 5'd20);
    step(1'b0, 4'd2, 8'h00, 1'b1, 1'b0, 1'b1, 5'd20);
    cpu_wr = 1'b0; ch_playing = 1'b0; cpu_idx = 4'd2; #2;
    chk("R7", cpu_rdata, 8'h3C);
    @(negedge clk);
    cpu_idx = 4'd10; #2;
    chk("R7", cpu_rdata, model[10]);
    @(negedge clk);

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic pl, win, nv, wr;
      pl  = ($urandom % 4) != 0;
      win = ($urandom % 3) == 0;
      nv  = ($urandom % 2) == 1;
      wr  = ($urandom % 3) == 0;
      step(wr, 4'($urandom), 8'($urandom), pl, win, nv, 5'($urandom));
    end
    readback_all("R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule